// File: doc/BRIEF.md
# Power-Fail Chip-Enable Gate

This block decides, from a digital supply-status flag, when host accesses to on-chip memory and the chip enable of an external SRAM may pass. When the supply drops below its trip point, host access is cut off, the write-protect flag is raised and the SRAM enable output is forced inactive. All of this happens in the same cycle, without waiting for a clock edge. When the supply returns, a lockout counter must see a programmable number of clock-enable ticks before anything opens again. With a 1 kHz tick and the default count of 200, the lockout lasts 200 ms.

A three-state controller sequences the block. The states are `ST_FAIL` (supply low), `ST_LOCK` (counting the lockout) and `ST_OPEN` (normal operation). The transitions are:
- `ST_FAIL` to `ST_LOCK` when the supply flag rises.
- `ST_LOCK` to `ST_OPEN` on the tick that completes the count.
- `ST_LOCK` to `ST_FAIL` and `ST_OPEN` to `ST_FAIL` whenever the supply flag drops.

Once the block is open:
- The SRAM enable output follows its input through purely combinational logic.
- The internal access enable is granted to an active host chip select, but only while the oscillator-ready status is high.

An active-low hold input blocks both paths whenever it is low, without disturbing the controller state.

Top module: `pwrfail_enable_gate`

## Requirements
- R1: While `supply_ok` is 0, `access_en` is 0 and `wr_protect` is 1 in the same cycle, whatever `host_cs_n`, `osc_ready` and `hold_n` are.
- R2: While `supply_ok` is 0, `ram_en_out_n` is 1 regardless of `ram_en_in_n`.
- R3: After `supply_ok` rises, `lockout_busy` is 1 and `ram_en_out_n`=1, `access_en`=0, `wr_protect`=1 until LOCK_TICKS cycles with `tick`=1 have been seen. The block opens on the clock edge that samples the LOCK_TICKS-th tick.
- R4: When open with `hold_n`=1, `access_en` = 1 exactly when `host_cs_n`=0 and `osc_ready`=1, and `wr_protect` is 0.
- R5: When open with `hold_n`=1, `ram_en_out_n` equals `ram_en_in_n` combinationally, in the same cycle.
- R6: While `hold_n` is 0, `ram_en_out_n` is 1 and `access_en` is 0. The controller state is unchanged, so releasing `hold_n` restores R4/R5 behaviour at once.
- R7: A drop of `supply_ok` during the lockout discards the partial count, and a full LOCK_TICKS ticks are needed after the next rise.
- R8: Ticks seen while `supply_ok` is 0, or after the block is open, have no effect: `lockout_busy` stays 0.
- R9: After `rst_n` the controller is in `ST_FAIL`: `lockout_busy`=0, `wr_protect`=1, `ram_en_out_n`=1, `access_en`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low flop reset |
| supply_ok | input | 1 | 1 when the supply is above the trip point |
| hold_n | input | 1 | Active-low functional reset that blocks access |
| tick | input | 1 | Clock-enable tick for the lockout count |
| osc_ready | input | 1 | Oscillator running and divider chain out of reset |
| host_cs_n | input | 1 | Active-low host chip select |
| ram_en_in_n | input | 1 | Active-low external SRAM enable request |
| ram_en_out_n | output | 1 | Gated active-low SRAM enable |
| access_en | output | 1 | Internal access enable for the bus interface |
| wr_protect | output | 1 | 1 while writes are blocked by supply state |
| lockout_busy | output | 1 | 1 while the power-up lockout is counting |

## Verification
A controller stuck in or wrongly entering `ST_OPEN` shows up at once at the ports. Once the input sweep runs, `ram_en_out_n` no longer tracks `ram_en_in_n`, or `wr_protect` flips, in the very cycle the inputs are applied. A counter that keeps a stale count, or that counts outside `ST_LOCK`, opens the block one or more ticks early. This is visible through `lockout_busy` dropping on the tick after a restart. An off-by-one in the terminal count moves the opening edge by exactly one tick, and the per-tick checks catch that.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_FAIL = 2'd0,
        ST_LOCK = 2'd1,
        ST_OPEN = 2'd2
    } pfg_state_e;
endpackage

// File: rtl/pfg_lock_counter.sv
module pfg_lock_counter #(
    parameter int LOCK_TICKS = 200,
    parameter int CW = $clog2(LOCK_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    output logic          done,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] LAST = CW'(LOCK_TICKS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (tick && count != LAST) begin
            count <= count + 1'b1;
        end
    end

    assign done = tick && !clear && (count == LAST);

    AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST); // R3
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0)); // R7
endmodule

// File: rtl/pfg_state_ctrl.sv
module pfg_state_ctrl
    import pfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic lock_done,
    output logic lock_clear,
    output logic busy,
    output logic open
);
    pfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAIL: if (supply_ok) state_d = ST_LOCK;
            ST_LOCK: begin
                if (!supply_ok)     state_d = ST_FAIL;
                else if (lock_done) state_d = ST_OPEN;
            end
            ST_OPEN: if (!supply_ok) state_d = ST_FAIL;
            default: state_d = ST_FAIL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAIL;
        else        state_q <= state_d;
    end

    always_comb begin
        lock_clear = 1'b1;
        busy       = 1'b0;
        open       = 1'b0;
        unique case (state_q)
            ST_FAIL: ;
            ST_LOCK: begin
                lock_clear = 1'b0;
                busy       = 1'b1;
            end
            ST_OPEN: open = 1'b1;
            default: ;
        endcase
    end

    AST_FAIL_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (state_q == ST_FAIL)); // R1
    AST_NO_EARLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCK && !lock_done) |=> (state_q != ST_OPEN)); // R3
    AST_FAIL_ONLY_TO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAIL) |=> (state_q != ST_OPEN)); // R8
endmodule

// File: rtl/pfg_out_gate.sv
module pfg_out_gate (
    input  logic open,
    input  logic supply_ok,
    input  logic hold_n,
    input  logic osc_ready,
    input  logic host_cs_n,
    input  logic ram_en_in_n,
    output logic ram_en_out_n,
    output logic access_en,
    output logic wr_protect
);
    logic powered;
    logic live;

    always_comb begin
        powered      = open && supply_ok;
        live         = powered && hold_n;
        ram_en_out_n = live ? ram_en_in_n : 1'b1;
        access_en    = live && osc_ready && !host_cs_n;
        wr_protect   = !powered;
    end
endmodule

// File: rtl/pwrfail_enable_gate.sv
module pwrfail_enable_gate #(
    parameter int LOCK_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic hold_n,
    input  logic tick,
    input  logic osc_ready,
    input  logic host_cs_n,
    input  logic ram_en_in_n,
    output logic ram_en_out_n,
    output logic access_en,
    output logic wr_protect,
    output logic lockout_busy
);
    localparam int CW = $clog2(LOCK_TICKS + 1);

    logic          lock_clear;
    logic          lock_done;
    logic          open;
    logic [CW-1:0] lock_count;

    pfg_lock_counter #(.LOCK_TICKS(LOCK_TICKS), .CW(CW)) counter_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (lock_clear),
        .tick  (tick),
        .done  (lock_done),
        .count (lock_count)
    );

    pfg_state_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_ok  (supply_ok),
        .lock_done  (lock_done),
        .lock_clear (lock_clear),
        .busy       (lockout_busy),
        .open       (open)
    );

    pfg_out_gate gate_i (
        .open         (open),
        .supply_ok    (supply_ok),
        .hold_n       (hold_n),
        .osc_ready    (osc_ready),
        .host_cs_n    (host_cs_n),
        .ram_en_in_n  (ram_en_in_n),
        .ram_en_out_n (ram_en_out_n),
        .access_en    (access_en),
        .wr_protect   (wr_protect)
    );

    AST_LOW_SUPPLY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (ram_en_out_n && !access_en && wr_protect)); // R2
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n |-> (ram_en_out_n && !access_en)); // R6
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        lockout_busy |-> (ram_en_out_n && !access_en && wr_protect)); // R3
endmodule

// File: tb/pwrfail_enable_gate_tb_top.sv
module pwrfail_enable_gate_tb_top;
    localparam int N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, hold_n = 1'b1, tick = 1'b0;
    logic osc_ready = 1'b1, host_cs_n = 1'b1, ram_en_in_n = 1'b1;
    logic ram_en_out_n, access_en, wr_protect, lockout_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwrfail_enable_gate #(.LOCK_TICKS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .hold_n(hold_n),
        .tick(tick), .osc_ready(osc_ready), .host_cs_n(host_cs_n),
        .ram_en_in_n(ram_en_in_n), .ram_en_out_n(ram_en_out_n),
        .access_en(access_en), .wr_protect(wr_protect),
        .lockout_busy(lockout_busy)
    );

    // packed as {busy, wr_protect, access_en, ram_en_out_n}
    function automatic logic [3:0] model(input bit online, input bit busy);
        bit live;
        live = online && supply_ok && hold_n;
        return {busy, !(online && supply_ok), live && osc_ready && !host_cs_n,
                live ? ram_en_in_n : 1'b1};
    endfunction

    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {lockout_busy, wr_protect, access_en, ram_en_out_n};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (busy,wp,acc,ram)", req, act, exp);
        end
    endtask

    task automatic sweep(input string req, input bit online, input bit busy);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            hold_n = i[3]; ram_en_in_n = i[2]; host_cs_n = i[1]; osc_ready = i[0];
            #1 chk(req, model(online, busy));
        end
        hold_n = 1'b1; ram_en_in_n = 1'b0; host_cs_n = 1'b0; osc_ready = 1'b1;
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R9 reset state", 4'b0101);
        sweep("R1/R2 low supply after reset", 1'b0, 1'b0);

        // R8: ticks while supply is low do nothing
        for (int k = 0; k < N + 2; k++) pulse_tick();
        #1 chk("R8 ticks in low supply", model(1'b0, 1'b0));

        // R3: lockout count
        @(negedge clk) supply_ok = 1'b1;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            #1 chk("R3 lockout blocks before tick", model(1'b0, 1'b1));
            pulse_tick();
            #1 chk("R3 lockout boundary", (k == N - 1) ? model(1'b1, 1'b0) : model(1'b0, 1'b1));
        end
        sweep("R4/R5/R6 open sweep", 1'b1, 1'b0);

        // R8: ticks after open have no effect
        for (int k = 0; k < N + 1; k++) pulse_tick();
        #1 chk("R8 ticks when open", model(1'b1, 1'b0));

        // R6: hold low then released, state kept
        @(negedge clk) hold_n = 1'b0; ram_en_in_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 chk("R6 hold blocks", model(1'b1, 1'b0));
        @(negedge clk) hold_n = 1'b1;
        #1 chk("R6 release restores", model(1'b1, 1'b0));

        // R1/R2: drop acts before the next edge
        @(negedge clk) supply_ok = 1'b0;
        #1 chk("R1/R2 immediate drop", model(1'b1, 1'b0));
        sweep("R1/R2 low supply sweep", 1'b0, 1'b0);

        // R7: drop mid-count restarts
        @(negedge clk) supply_ok = 1'b1;
        for (int k = 0; k < N - 1; k++) pulse_tick();
        #1 chk("R7 partial count", model(1'b0, 1'b1));
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        #1 chk("R7 after drop", model(1'b0, 1'b0));
        for (int k = 0; k < N; k++) begin
            pulse_tick();
            #1 chk("R7 full recount", (k == N - 1) ? model(1'b1, 1'b0) : model(1'b0, 1'b1));
        end
        sweep("R4/R5 open after recount", 1'b1, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule